// File: doc/BRIEF.md
# Multi-Core Power Estimator

The block turns one sampling interval of per-core activity into an estimate of total processor power. On a start pulse it captures, for each of four cores, the event counts (fetched micro-ops, retired floating-point ops, data-cache accesses), the halted and running fractions of the interval and the core's operating point index. It also captures a die temperature code and the current coefficient set. It then steps all of them through one shared signed multiplier. The result is a clock-gateable term and an ungateable term per core, both scaled by V² and the core frequency, plus an event term per core scaled by V². A single leakage term, quadratic in temperature and scaled by V, is added on top.

Software loads eight signed Q8.8 coefficients through a small write port. The supply voltage is the same for all cores, so the voltage used everywhere is the highest one that any core asks for. A single-cycle done pulse presents the saturated 32-bit total, which then stays on the output until the next result.

Top module: `power_estimator`

## Requirements
- R1: After reset, done and busy are 0 and power_out is 0.
- R2: A write with cfg_we=1 loads cfg_wdata, a signed Q8.8 value, into the coefficient slot at cfg_addr. The slots are 0 fetch, 1 floating-point, 2 data-cache, 3 gateable (halted), 4 ungateable (running), 5 temperature squared, 6 temperature, 7 constant. Writes to addresses 8 to 15 change no coefficient.
- R3: Each core's 3-bit operating point index k selects a voltage code of 352-24k (volts = code/256) and a frequency of 30-4k (units of 100 MHz). An index above 4 acts as 4. The shared voltage code V is the largest voltage code selected by any core.
- R4: With VSQ=(V·V)>>8, the dynamic sum D is the sum over cores of fetch·C0 + fp·C1 + dc·C2 + ((halt·C3 + run·C4)·f)>>>8. Here halt and run are 8-bit fractions of 256 and f is the core frequency. The dynamic power is (D·VSQ)>>>8.
- R5: With t the temperature code in units of 0.125 °C, the static sum S = ((C5·t·t)>>>6) + ((C6·t)>>>3) + C7 is added once, as (S·V)>>>8.
- R6: power_out is the dynamic power plus the static power, saturated to the signed 32-bit range.
- R7: The start pulse captures all data inputs and coefficients. Input changes and coefficient writes during a computation do not alter that result, but a coefficient write takes effect at the next start.
- R8: A start while busy is 1 is ignored and produces no extra done pulse.
- R9: done is a one-cycle pulse 30 cycles (6 per core plus 6) after the clock edge that accepted start. busy is 1 from that edge until done.
- R10: power_out holds its value between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 4 | Coefficient slot address |
| cfg_wdata | input | 16 | Signed Q8.8 coefficient value |
| start | input | 1 | Begin an estimate, capturing all inputs |
| fetch_cnt | input | 64 | Per-core fetched micro-op counts, core n at bits 16n+15:16n |
| fp_cnt | input | 64 | Per-core retired floating-point op counts |
| dc_cnt | input | 64 | Per-core data-cache access counts |
| halt_frac | input | 32 | Per-core halted fraction of 256, core n at bits 8n+7:8n |
| run_frac | input | 32 | Per-core running fraction of 256 |
| opp_sel | input | 12 | Per-core operating point index, core n at bits 3n+2:3n |
| temp_code | input | 11 | Die temperature in 0.125 °C steps |
| busy | output | 1 | Estimate in progress |
| done | output | 1 | One-cycle pulse, result valid |
| power_out | output | 32 | Saturated signed power estimate |

## Verification
The tests use several input sets. A set with equal operating points and positive coefficients confirms the basic sum. Mixed operating points show whether the largest voltage is picked rather than a per-core voltage. Out-of-range indices exercise the clamp. Negative coefficients expose sign handling in the shifts, and full-scale inputs with extreme coefficients of either sign reach positive and negative saturation. A run disturbed mid-way by new inputs, a coefficient write and a second start separates proper input capture from live sampling. The run after it, together with a write to an unused address, shows which coefficient writes actually land.

// File: rtl/power_estimator.sv
module power_estimator #(
  parameter int NCORES = 4,
  parameter int CNTW   = 16,
  parameter int FRACW  = 8,
  parameter int COEFW  = 16,
  parameter int VOLTW  = 9,
  parameter int TEMPW  = 11,
  parameter int FREQW  = 5,
  parameter int ACCW   = 48,
  parameter int OUTW   = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [3:0]                cfg_addr,
  input  logic [COEFW-1:0]          cfg_wdata,
  input  logic                      start,
  input  logic [NCORES*CNTW-1:0]    fetch_cnt,
  input  logic [NCORES*CNTW-1:0]    fp_cnt,
  input  logic [NCORES*CNTW-1:0]    dc_cnt,
  input  logic [NCORES*FRACW-1:0]   halt_frac,
  input  logic [NCORES*FRACW-1:0]   run_frac,
  input  logic [NCORES*3-1:0]       opp_sel,
  input  logic [TEMPW-1:0]          temp_code,
  output logic                      busy,
  output logic                      done,
  output logic [OUTW-1:0]           power_out
);
  localparam int SELW  = 3;
  localparam int NCOEF = 8;
  localparam int AW    = ACCW - 8;
  localparam int BW    = COEFW + 2;
  localparam int CIDX  = (NCORES > 1) ? $clog2(NCORES) : 1;
  localparam logic [CIDX-1:0] LASTC = CIDX'(NCORES - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_PREP, PH_CORE, PH_FIN} phase_t;
  typedef enum logic [2:0] {D_VSQ, D_TSQ, D_STAT, D_TMP, D_ACC} dst_t;

  function automatic logic [VOLTW-1:0] opp_volt(input logic [SELW-1:0] s);
    int k;
    k = (s > 3'd4) ? 4 : int'(s);
    return VOLTW'(352 - 24 * k);
  endfunction

  function automatic logic [FREQW-1:0] opp_freq(input logic [SELW-1:0] s);
    int k;
    k = (s > 3'd4) ? 4 : int'(s);
    return FREQW'(30 - 4 * k);
  endfunction

  function automatic logic signed [BW-1:0] sx(input logic [COEFW-1:0] c);
    return {{(BW-COEFW){c[COEFW-1]}}, c};
  endfunction

  logic [COEFW-1:0] coef_q [NCOEF];
  logic [COEFW-1:0] coef_s [NCOEF];
  logic [NCORES*CNTW-1:0]  fo_s, fp_s, dc_s;
  logic [NCORES*FRACW-1:0] hf_s, rf_s;
  logic [NCORES*SELW-1:0]  opp_s;
  logic [TEMPW-1:0]        t_s;
  logic [VOLTW-1:0]        vmax_s, vmax_in;
  logic signed [ACCW-1:0]  vsq_q, tsq_q, stat_q, tmp_q, acc_q;
  phase_t                  ph;
  logic [2:0]              sub;
  logic [CIDX-1:0]         core;

  logic signed [AW-1:0]    op_a;
  logic signed [BW-1:0]    op_b;
  logic [1:0]              shamt;
  dst_t                    dst;
  logic                    accum;
  logic signed [ACCW-1:0]  extra, prod, shifted, old, nxt;
  logic [OUTW-1:0]         sat_out;

  always_comb begin
    logic [VOLTW-1:0] vc;
    vmax_in = '0;
    for (int i = 0; i < NCORES; i++) begin
      vc = opp_volt(opp_sel[i*SELW +: SELW]);
      if (vc > vmax_in) vmax_in = vc;
    end
  end

  wire [CNTW-1:0]  cur_fo  = fo_s[core*CNTW +: CNTW];
  wire [CNTW-1:0]  cur_fp  = fp_s[core*CNTW +: CNTW];
  wire [CNTW-1:0]  cur_dc  = dc_s[core*CNTW +: CNTW];
  wire [FRACW-1:0] cur_hf  = hf_s[core*FRACW +: FRACW];
  wire [FRACW-1:0] cur_rf  = rf_s[core*FRACW +: FRACW];
  wire [FREQW-1:0] cur_f   = opp_freq(opp_s[core*SELW +: SELW]);

  always_comb begin
    op_a  = '0;
    op_b  = '0;
    shamt = 2'd0;
    dst   = D_ACC;
    accum = 1'b0;
    extra = '0;
    case (ph)
      PH_PREP: begin
        case (sub)
          3'd0: begin
            op_a = {{(AW-VOLTW){1'b0}}, vmax_s};
            op_b = {{(BW-VOLTW){1'b0}}, vmax_s};
            shamt = 2'd3; dst = D_VSQ;
          end
          3'd1: begin
            op_a = {{(AW-TEMPW){1'b0}}, t_s};
            op_b = {{(BW-TEMPW){1'b0}}, t_s};
            dst = D_TSQ;
          end
          3'd2: begin
            op_a = tsq_q[AW-1:0];
            op_b = sx(coef_s[5]);
            shamt = 2'd2; dst = D_STAT;
          end
          default: begin
            op_a = {{(AW-TEMPW){1'b0}}, t_s};
            op_b = sx(coef_s[6]);
            shamt = 2'd1; dst = D_STAT; accum = 1'b1;
            extra = {{(ACCW-COEFW){coef_s[7][COEFW-1]}}, coef_s[7]};
          end
        endcase
      end
      PH_CORE: begin
        case (sub)
          3'd0: begin
            op_a = {{(AW-FRACW){1'b0}}, cur_hf};
            op_b = sx(coef_s[3]);
            dst = D_TMP;
          end
          3'd1: begin
            op_a = {{(AW-FRACW){1'b0}}, cur_rf};
            op_b = sx(coef_s[4]);
            dst = D_TMP; accum = 1'b1;
          end
          3'd2: begin
            op_a = tmp_q[AW-1:0];
            op_b = {{(BW-FREQW){1'b0}}, cur_f};
            shamt = 2'd3; accum = 1'b1;
          end
          3'd3: begin
            op_a = {{(AW-CNTW){1'b0}}, cur_fo};
            op_b = sx(coef_s[0]);
            accum = 1'b1;
          end
          3'd4: begin
            op_a = {{(AW-CNTW){1'b0}}, cur_fp};
            op_b = sx(coef_s[1]);
            accum = 1'b1;
          end
          default: begin
            op_a = {{(AW-CNTW){1'b0}}, cur_dc};
            op_b = sx(coef_s[2]);
            accum = 1'b1;
          end
        endcase
      end
      PH_FIN: begin
        if (sub == 3'd0) begin
          op_a = acc_q[AW-1:0];
          op_b = vsq_q[BW-1:0];
          shamt = 2'd3;
        end else begin
          op_a = stat_q[AW-1:0];
          op_b = {{(BW-VOLTW){1'b0}}, vmax_s};
          shamt = 2'd3; accum = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign prod = $signed(ACCW'(op_a * op_b));

  always_comb begin
    case (shamt)
      2'd0:    shifted = prod;
      2'd1:    shifted = prod >>> 3;
      2'd2:    shifted = prod >>> 6;
      default: shifted = prod >>> 8;
    endcase
    case (dst)
      D_VSQ:   old = vsq_q;
      D_TSQ:   old = tsq_q;
      D_STAT:  old = stat_q;
      D_TMP:   old = tmp_q;
      default: old = acc_q;
    endcase
  end

  assign nxt = (accum ? old : '0) + shifted + extra;

  wire [ACCW-OUTW:0] hi_bits = nxt[ACCW-1:OUTW-1];
  wire ovf = !((&hi_bits) || (~|hi_bits));
  assign sat_out = ovf ? (nxt[ACCW-1] ? {1'b1, {(OUTW-1){1'b0}}} : {1'b0, {(OUTW-1){1'b1}}})
                       : nxt[OUTW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCOEF; i++) coef_q[i] <= '0;
    end else if (cfg_we && !cfg_addr[3]) begin
      coef_q[cfg_addr[2:0]] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= PH_IDLE; sub <= '0; core <= '0;
      busy <= 1'b0; done <= 1'b0; power_out <= '0;
      for (int i = 0; i < NCOEF; i++) coef_s[i] <= '0;
      fo_s <= '0; fp_s <= '0; dc_s <= '0; hf_s <= '0; rf_s <= '0;
      opp_s <= '0; t_s <= '0; vmax_s <= '0;
      vsq_q <= '0; tsq_q <= '0; stat_q <= '0; tmp_q <= '0; acc_q <= '0;
    end else begin
      done <= 1'b0;
      if (ph == PH_IDLE) begin
        if (start) begin
          for (int i = 0; i < NCOEF; i++) coef_s[i] <= coef_q[i];
          fo_s <= fetch_cnt; fp_s <= fp_cnt; dc_s <= dc_cnt;
          hf_s <= halt_frac; rf_s <= run_frac; opp_s <= opp_sel;
          t_s <= temp_code; vmax_s <= vmax_in;
          acc_q <= '0; sub <= '0; core <= '0;
          ph <= PH_PREP; busy <= 1'b1;
        end
      end else begin
        case (dst)
          D_VSQ:   vsq_q  <= nxt;
          D_TSQ:   tsq_q  <= nxt;
          D_STAT:  stat_q <= nxt;
          D_TMP:   tmp_q  <= nxt;
          default: acc_q  <= nxt;
        endcase
        case (ph)
          PH_PREP:
            if (sub == 3'd3) begin
              ph <= PH_CORE; sub <= '0; core <= '0;
            end else sub <= sub + 3'd1;
          PH_CORE:
            if (sub == 3'd5) begin
              sub <= '0;
              if (core == LASTC) ph <= PH_FIN;
              else core <= core + 1'b1;
            end else sub <= sub + 3'd1;
          default:
            if (sub == 3'd1) begin
              ph <= PH_IDLE; sub <= '0; busy <= 1'b0;
              done <= 1'b1; power_out <= sat_out;
            end else sub <= sub + 3'd1;
        endcase
      end
    end
  end
endmodule

module power_estimator_chk #(
  parameter int NCORES = 4,
  parameter int OUTW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [OUTW-1:0] power_out
);
  localparam int LAT = 6 * NCORES + 6;
  logic [15:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) lat_cnt <= '0;
    else if (start && !busy) lat_cnt <= '0;
    else if (busy) lat_cnt <= lat_cnt + 16'd1;
  end

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n) done |-> (lat_cnt == 16'(LAT)));
  a_r9_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  a_r8_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  a_r10_output_hold: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(power_out));
endmodule

bind power_estimator power_estimator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .power_out(power_out)
);

// File: tb/tb_power_estimator.sv
module tb_power_estimator;
  localparam int N = 4;
  localparam int LAT = 6 * N + 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic start = 1'b0;
  logic [N*16-1:0] fetch_cnt = '0, fp_cnt = '0, dc_cnt = '0;
  logic [N*8-1:0] halt_frac = '0, run_frac = '0;
  logic [N*3-1:0] opp_sel = '0;
  logic [10:0] temp_code = '0;
  logic busy, done;
  logic [31:0] power_out;

  power_estimator dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .start(start), .fetch_cnt(fetch_cnt), .fp_cnt(fp_cnt), .dc_cnt(dc_cnt),
    .halt_frac(halt_frac), .run_frac(run_frac), .opp_sel(opp_sel), .temp_code(temp_code),
    .busy(busy), .done(done), .power_out(power_out)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int fo[N], fpo[N], dca[N], hf[N], rf[N], os[N];
  int tcode;
  longint cm[8];
  longint exp_q[$];
  longint scyc_q[$];
  string  tag_q[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint model();
    longint vm, vsq, dyn, tmp, st, tot, v, k, f;
    vm = 0; dyn = 0;
    for (int n = 0; n < N; n++) begin
      k = (os[n] > 4) ? 4 : os[n];
      v = 352 - 24 * k;
      if (v > vm) vm = v;
    end
    vsq = (vm * vm) >>> 8;
    for (int n = 0; n < N; n++) begin
      k = (os[n] > 4) ? 4 : os[n];
      f = 30 - 4 * k;
      tmp = longint'(hf[n]) * cm[3] + longint'(rf[n]) * cm[4];
      dyn += (tmp * f) >>> 8;
      dyn += longint'(fo[n]) * cm[0] + longint'(fpo[n]) * cm[1] + longint'(dca[n]) * cm[2];
    end
    tot = (dyn * vsq) >>> 8;
    st = ((cm[5] * tcode * tcode) >>> 6) + ((cm[6] * tcode) >>> 3) + cm[7];
    tot += (st * vm) >>> 8;
    if (tot > 64'sd2147483647) tot = 64'sd2147483647;
    if (tot < -64'sd2147483648) tot = -64'sd2147483648;
    return tot;
  endfunction

  task automatic wr_coef(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 8) cm[a] = longint'($signed(16'(d)));
  endtask

  task automatic apply_inputs();
    for (int n = 0; n < N; n++) begin
      fetch_cnt[n*16 +: 16] = 16'(fo[n]);
      fp_cnt[n*16 +: 16]    = 16'(fpo[n]);
      dc_cnt[n*16 +: 16]    = 16'(dca[n]);
      halt_frac[n*8 +: 8]   = 8'(hf[n]);
      run_frac[n*8 +: 8]    = 8'(rf[n]);
      opp_sel[n*3 +: 3]     = 3'(os[n]);
    end
    temp_code = 11'(tcode);
  endtask

  task automatic launch(input string tag);
    @(negedge clk);
    apply_inputs();
    exp_q.push_back(model());
    scyc_q.push_back(cyc);
    tag_q.push_back(tag);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_core(input int n, input int a, input int b, input int c,
                          input int h, input int r, input int o);
    fo[n] = a; fpo[n] = b; dca[n] = c; hf[n] = h; rf[n] = r; os[n] = o;
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected done", 1, 0);
      end else begin
        longint e, s;
        string t;
        e = exp_q.pop_front();
        s = scyc_q.pop_front();
        t = tag_q.pop_front();
        chk(longint'($signed(power_out)) == e, t, longint'($signed(power_out)), e);
        chk((cyc - s) == longint'(LAT + 1), "R9 latency", cyc - s, LAT + 1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) cm[i] = 0;
    for (int n = 0; n < N; n++) set_core(n, 0, 0, 0, 0, 0, 0);
    tcode = 0;
    repeat (4) @(negedge clk);
    chk(done == 1'b0, "R1 done", longint'(done), 0);
    chk(busy == 1'b0, "R1 busy", longint'(busy), 0);
    chk(power_out == '0, "R1 power_out", longint'(power_out), 0);
    rst_n = 1'b1;

    wr_coef(0, 256); wr_coef(1, 512); wr_coef(2, 128); wr_coef(3, 64);
    wr_coef(4, 256); wr_coef(5, 16); wr_coef(6, 128); wr_coef(7, 768);

    // R4 R5 R6: equal operating points
    set_core(0, 1000, 200, 300, 64, 192, 0);
    set_core(1, 50, 0, 10, 255, 1, 0);
    set_core(2, 40000, 1234, 9999, 0, 255, 0);
    set_core(3, 7, 3, 1, 128, 128, 0);
    tcode = 520;
    launch("R4 R5 R6 base");
    wait_idle();

    // R10: output holds
    begin
      logic [31:0] held;
      held = power_out;
      repeat (12) @(negedge clk);
      chk(power_out == held, "R10 hold", longint'(power_out), longint'(held));
    end

    // R3: mixed operating points, max voltage
    set_core(0, 300, 20, 40, 10, 246, 3);
    set_core(1, 800, 70, 90, 30, 226, 1);
    set_core(2, 100, 5, 7, 200, 56, 4);
    set_core(3, 600, 60, 66, 100, 156, 2);
    tcode = 777;
    launch("R3 max voltage");
    wait_idle();

    // R3: indices above 4 clamp
    set_core(0, 500, 50, 50, 20, 236, 7);
    set_core(1, 500, 50, 50, 20, 236, 6);
    set_core(2, 500, 50, 50, 20, 236, 5);
    set_core(3, 500, 50, 50, 20, 236, 7);
    launch("R3 clamp");
    wait_idle();

    // R4 R5: negative coefficients
    wr_coef(0, -300); wr_coef(3, -100); wr_coef(5, -7); wr_coef(6, -555); wr_coef(7, -1000);
    set_core(0, 1111, 333, 77, 90, 166, 2);
    set_core(1, 22, 4444, 5, 17, 239, 0);
    set_core(2, 3000, 1, 800, 250, 6, 3);
    set_core(3, 9, 90, 900, 1, 255, 1);
    tcode = 1999;
    launch("R4 R5 negative");
    wait_idle();

    // R6: positive saturation
    for (int i = 0; i < 8; i++) wr_coef(i, 32767);
    for (int n = 0; n < N; n++) set_core(n, 65535, 65535, 65535, 255, 255, 0);
    tcode = 2047;
    launch("R6 saturate high");
    wait_idle();

    // R6: negative saturation
    for (int i = 0; i < 8; i++) wr_coef(i, -32768);
    launch("R6 saturate low");
    wait_idle();

    // R7 R8: disturbed computation
    wr_coef(0, 256); wr_coef(1, 256); wr_coef(2, 256); wr_coef(3, 256);
    wr_coef(4, 256); wr_coef(5, 8); wr_coef(6, 64); wr_coef(7, 512);
    set_core(0, 100, 10, 20, 100, 156, 0);
    set_core(1, 200, 20, 30, 50, 206, 1);
    set_core(2, 300, 30, 40, 25, 231, 2);
    set_core(3, 400, 40, 50, 5, 251, 3);
    tcode = 400;
    launch("R7 captured inputs");
    repeat (5) @(negedge clk);
    for (int n = 0; n < N; n++) set_core(n, 9000, 9000, 9000, 0, 255, 4);
    tcode = 1500;
    apply_inputs();
    wr_coef(0, 5000);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();

    // R2 R7: new coefficient used on next start
    launch("R2 R7 new coefficient");
    wait_idle();

    // R2: writes to unused addresses ignored
    wr_coef(9, 1234);
    wr_coef(15, -1);
    launch("R2 unused address");
    wait_idle();

    // R8: no stray done pulses
    repeat (2 * LAT) @(negedge clk);
    chk(exp_q.size() == 0, "R8 pending", exp_q.size(), 0);
    chk(busy == 1'b0, "R9 idle busy", longint'(busy), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule